// File: doc/BRIEF.md
# Processor Status Word with Banked Stack Pointer

This block keeps the processor status word of a 32-bit core together with the stack pointer (general register R15) and two saved stack pointers, one for system mode and one for user mode. The status word is assembled from a six-flag condition byte, a three-flag control field and a five-bit interrupt mask. Each part, and the whole word, can be written and read through one control port. A second write port lets the general register file write R15 directly.

The stack-select flag S picks the stack that R15 shows. When a write changes S, the block stores R15 into the saved pointer of the stack being left and loads R15 from the saved pointer of the stack being entered, all in one clock edge. Two alias selects reach the system and user stack pointers. When an alias names the stack that is live in R15, it reads and writes R15 itself. Writes to the interrupt mask cannot move it from the upper half of its range into the lower half.

Top module: `psw_bank`

## Requirements
- R1: After a synchronous active-low reset, the status word, R15 and both saved stack pointers are zero.
- R2: The status word reads as the condition byte in bits 7:0, the control field in bits 10:8 and the mask in bits 20:16, with every other bit zero. The condition byte has C at bit 0, V at 1, Z at 2, N at 3, I at 4, S at 5, and bits 7:6 read zero. Write data in the zero bits has no effect.
- R3: A control-field write stores write data bits 2:0 as T (bit 0), D0 (bit 1) and D1 (bit 2).
- R4: A mask write whose value is below 16, made while the mask is 16 or more, stores the value plus 16.
- R5: Every other mask write stores the written value unchanged.
- R6: A write that takes S from 1 to 0 saves R15 into the user saved pointer and loads R15 from the system saved pointer.
- R7: A write that takes S from 0 to 1 saves R15 into the system saved pointer and loads R15 from the user saved pointer.
- R8: With S at 0, the system-stack alias reads R15 and the user-stack alias reads the user saved pointer. With S at 1, the user-stack alias reads R15 and the system-stack alias reads the system saved pointer.
- R9: A write to an alias goes to R15 when that alias names the live stack, and to the saved pointer otherwise.
- R10: A whole-word write updates the condition byte, control field and mask through the rules of R3 to R7, including the swap and the mask floor.
- R11: A swap overrides every direct R15 write in its cycle. A control-port write that lands on R15 overrides the register-file R15 write.
- R12: Select codes on both ports: 0 whole word, 1 condition byte, 2 control field, 3 mask, 4 R15, 5 system-stack alias, 6 user-stack alias. Code 7 reads zero and writes nothing. Part reads are right-aligned with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control-port write enable |
| ctl_sel | input | 3 | Control-port write target (R12 codes) |
| ctl_wdata | input | 32 | Control-port write data |
| gr_we | input | 1 | Register-file write enable for R15 |
| gr_wdata | input | 32 | Register-file write data for R15 |
| rd_sel | input | 3 | Read target (R12 codes) |
| rd_data | output | 32 | Combinational read data |
| status_out | output | 32 | Current status word |
| sp_out | output | 32 | Current R15 |

## Verification
Assertions check on every cycle that the mask never falls out of its upper half, that S changes only after a condition write, that each swap direction moves R15 and the saved pointers as required, and that an uncontested register-file write lands in R15. The bench scenarios cover the rest: the field layout and the ignored bits in the read-back word, alias routing for each value of S, the priority order when writes collide, and whole-word writes that apply both the swap and the mask floor at once.

// File: rtl/psw_pkg.sv
// Shared field geometry and select codes for the status/stack block.
// Assumes a 32-bit data path; positions follow the status-word layout.
package psw_pkg;
    localparam int WORD_W   = 32;
    localparam int COND_W   = 6;
    localparam int CTRL_W   = 3;
    localparam int MASK_W   = 5;
    localparam int CTRL_LSB = 8;
    localparam int MASK_LSB = 16;
    localparam int S_BIT    = 5;

    typedef enum logic [2:0] {
        SEL_WORD   = 3'd0,
        SEL_COND   = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_MASK   = 3'd3,
        SEL_SP     = 3'd4,
        SEL_SYS_SP = 3'd5,
        SEL_USR_SP = 3'd6,
        SEL_NONE   = 3'd7
    } psw_sel_e;
endpackage

// File: rtl/psw_flags.sv
// Condition byte and control field registers.
// Flags whether a condition write flips the stack-select bit so that the
// stack bank can swap in the same edge. Assumes one writer per field.
module psw_flags #(
    parameter int COND_W = 6,
    parameter int CTRL_W = 3,
    parameter int S_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond_we,
    input  logic [COND_W-1:0] cond_d,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_d,
    output logic [COND_W-1:0] cond_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              s_cur,
    output logic              s_flip
);
    assign s_cur  = cond_q[S_BIT];
    assign s_flip = cond_we && (cond_d[S_BIT] != cond_q[S_BIT]);

    // Purpose: hold the condition flags.
    always_ff @(posedge clk) begin
        if (!rst_n)       cond_q <= '0;
        else if (cond_we) cond_q <= cond_d;
    end

    // Purpose: hold the control flags.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_d;
    end

    // S moves only as the result of a condition write (R10)
    assert_s_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cond_q[S_BIT]) |-> ($past(cond_we) || !$past(rst_n)));
endmodule

// File: rtl/psw_mask.sv
// Interrupt level mask register with a floor rule: once in the upper half
// of its range, a write aimed at the lower half lands in the upper half.
module psw_mask #(
    parameter int MASK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MASK_W-1:0] d,
    output logic [MASK_W-1:0] q
);
    localparam int TOP = MASK_W - 1;

    logic [MASK_W-1:0] next_val;

    // Purpose: lift a lower-half value when the mask sits in the upper half.
    always_comb begin
        next_val = d;
        if (q[TOP] && !d[TOP]) next_val[TOP] = 1'b1;
    end

    // Purpose: hold the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= next_val;
    end

    // Once in the upper half, the mask stays there (R4)
    assert_mask_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q[TOP] |=> q[TOP]);
endmodule

// File: rtl/psw_stack.sv
// R15 plus the system and user saved stack pointers.
// Swaps on an S change; routes alias reads and writes to R15 or the saved
// copy by the current S. Priority: swap, then a control write on R15, then
// the register-file write.
module psw_stack #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_cur,
    input  logic         swap,
    input  logic         we_sp,
    input  logic         we_sys,
    input  logic         we_usr,
    input  logic [W-1:0] ctl_d,
    input  logic         gr_we,
    input  logic [W-1:0] gr_d,
    output logic [W-1:0] r15_q,
    output logic [W-1:0] sys_view,
    output logic [W-1:0] usr_view
);
    logic [W-1:0] ssp_q;
    logic [W-1:0] usp_q;
    logic         ctl_hits_r15;

    assign ctl_hits_r15 = we_sp || (we_sys && !s_cur) || (we_usr && s_cur);
    assign sys_view     = s_cur ? ssp_q : r15_q;
    assign usr_view     = s_cur ? r15_q : usp_q;

    // Purpose: update R15 by swap, control write or register-file write.
    always_ff @(posedge clk) begin
        if (!rst_n)            r15_q <= '0;
        else if (swap)         r15_q <= s_cur ? ssp_q : usp_q;
        else if (ctl_hits_r15) r15_q <= ctl_d;
        else if (gr_we)        r15_q <= gr_d;
    end

    // Purpose: update the system saved pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ssp_q <= '0;
        else if (swap && !s_cur)    ssp_q <= r15_q;
        else if (we_sys && s_cur)   ssp_q <= ctl_d;
    end

    // Purpose: update the user saved pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 usp_q <= '0;
        else if (swap && s_cur)     usp_q <= r15_q;
        else if (we_usr && !s_cur)  usp_q <= ctl_d;
    end

    // S 1->0: R15 saved to user copy, reloaded from system copy (R6)
    assert_swap_to_sys_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && s_cur) |=> (r15_q == $past(ssp_q)) && (usp_q == $past(r15_q)));

    // S 0->1: R15 saved to system copy, reloaded from user copy (R7)
    assert_swap_to_usr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !s_cur) |=> (r15_q == $past(usp_q)) && (ssp_q == $past(r15_q)));

    // Uncontested register-file write reaches R15 (R11)
    assert_gr_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (gr_we && !swap && !we_sp && !we_sys && !we_usr) |=> (r15_q == $past(gr_d)));
endmodule

// File: rtl/psw_bank.sv
// Top of the status-word / banked-stack block.
// Decodes the control port onto the flag, mask and stack registers,
// assembles the status word and drives the combinational read mux.
module psw_bank
    import psw_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_we,
    input  logic [2:0]   ctl_sel,
    input  logic [W-1:0] ctl_wdata,
    input  logic         gr_we,
    input  logic [W-1:0] gr_wdata,
    input  logic [2:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] status_out,
    output logic [W-1:0] sp_out
);
    psw_sel_e wsel;
    psw_sel_e rsel;
    logic     is_word;

    logic              cond_we, ctrl_we, mask_we;
    logic [COND_W-1:0] cond_d, cond_q;
    logic [CTRL_W-1:0] ctrl_d, ctrl_q;
    logic [MASK_W-1:0] mask_d, mask_q;
    logic              s_cur, s_flip;
    logic [W-1:0]      r15_q, sys_view, usr_view;
    logic [W-1:0]      word;

    assign wsel    = psw_sel_e'(ctl_sel);
    assign rsel    = psw_sel_e'(rd_sel);
    assign is_word = (wsel == SEL_WORD);

    // Purpose: route the control-port write onto the individual fields.
    always_comb begin
        cond_we = ctl_we && (is_word || wsel == SEL_COND);
        ctrl_we = ctl_we && (is_word || wsel == SEL_CTRL);
        mask_we = ctl_we && (is_word || wsel == SEL_MASK);
        cond_d  = ctl_wdata[COND_W-1:0];
        ctrl_d  = is_word ? ctl_wdata[CTRL_LSB +: CTRL_W] : ctl_wdata[CTRL_W-1:0];
        mask_d  = is_word ? ctl_wdata[MASK_LSB +: MASK_W] : ctl_wdata[MASK_W-1:0];
    end

    psw_flags #(.COND_W(COND_W), .CTRL_W(CTRL_W), .S_BIT(S_BIT)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .cond_we(cond_we), .cond_d(cond_d),
        .ctrl_we(ctrl_we), .ctrl_d(ctrl_d),
        .cond_q(cond_q), .ctrl_q(ctrl_q),
        .s_cur(s_cur), .s_flip(s_flip)
    );

    psw_mask #(.MASK_W(MASK_W)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .we(mask_we), .d(mask_d), .q(mask_q)
    );

    psw_stack #(.W(W)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .s_cur(s_cur), .swap(s_flip),
        .we_sp(ctl_we && wsel == SEL_SP),
        .we_sys(ctl_we && wsel == SEL_SYS_SP),
        .we_usr(ctl_we && wsel == SEL_USR_SP),
        .ctl_d(ctl_wdata),
        .gr_we(gr_we), .gr_d(gr_wdata),
        .r15_q(r15_q), .sys_view(sys_view), .usr_view(usr_view)
    );

    // Purpose: assemble the status word with zeros in unused bits.
    always_comb begin
        word = '0;
        word[COND_W-1:0]             = cond_q;
        word[CTRL_LSB +: CTRL_W]     = ctrl_q;
        word[MASK_LSB +: MASK_W]     = mask_q;
    end

    // Purpose: select the read data by the read code.
    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_WORD:   rd_data = word;
            SEL_COND:   rd_data[COND_W-1:0] = cond_q;
            SEL_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
            SEL_MASK:   rd_data[MASK_W-1:0] = mask_q;
            SEL_SP:     rd_data = r15_q;
            SEL_SYS_SP: rd_data = sys_view;
            SEL_USR_SP: rd_data = usr_view;
            default:    rd_data = '0;
        endcase
    end

    assign status_out = word;
    assign sp_out     = r15_q;

    // A write to code 7 leaves the status word and R15 untouched (R12)
    assert_none_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wsel == SEL_NONE && !gr_we) |=> $stable(status_out) && $stable(sp_out));
endmodule

// File: tb/sim_psw_bank.sv
`timescale 1ns/1ps
module sim_psw_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_sel = 3'd0;
    logic [31:0] ctl_wdata = '0;
    logic        gr_we = 1'b0;
    logic [31:0] gr_wdata = '0;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_data, status_out, sp_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0]  m_cond;
    logic [2:0]  m_ctrl;
    logic [4:0]  m_mask;
    logic [31:0] m_r15, m_ssp, m_usp;

    always #4 clk = ~clk;

    psw_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .gr_we(gr_we), .gr_wdata(gr_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .status_out(status_out), .sp_out(sp_out)
    );

    function automatic logic [4:0] floor_mask(logic [4:0] cur, logic [4:0] v);
        return (cur >= 5'd16 && v < 5'd16) ? v + 5'd16 : v;
    endfunction

    function automatic logic [31:0] exp_word();
        return {11'b0, m_mask, 5'b0, m_ctrl, 2'b0, m_cond};
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] s);
        case (s)
            3'd0: return exp_word();
            3'd1: return {26'b0, m_cond};
            3'd2: return {29'b0, m_ctrl};
            3'd3: return {27'b0, m_mask};
            3'd4: return m_r15;
            3'd5: return m_cond[5] ? m_ssp : m_r15;
            3'd6: return m_cond[5] ? m_r15 : m_usp;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_cond = '0; m_ctrl = '0; m_mask = '0;
        m_r15 = '0; m_ssp = '0; m_usp = '0;
    endtask

    task automatic model_apply(bit we, logic [2:0] sel, logic [31:0] d, bit gwe, logic [31:0] gd);
        logic s_old = m_cond[5];
        bit swap = 1'b0;
        bit hits = 1'b0;
        if (we) begin
            case (sel)
                3'd0: begin
                    swap = (d[5] != s_old); m_cond = d[5:0];
                    m_ctrl = d[10:8]; m_mask = floor_mask(m_mask, d[20:16]);
                end
                3'd1: begin swap = (d[5] != s_old); m_cond = d[5:0]; end
                3'd2: m_ctrl = d[2:0];
                3'd3: m_mask = floor_mask(m_mask, d[4:0]);
                3'd4: begin m_r15 = d; hits = 1'b1; end
                3'd5: if (!s_old) begin m_r15 = d; hits = 1'b1; end else m_ssp = d;
                3'd6: if (s_old) begin m_r15 = d; hits = 1'b1; end else m_usp = d;
                default: ;
            endcase
        end
        if (swap) begin
            if (s_old) begin m_usp = m_r15; m_r15 = m_ssp; end
            else       begin m_ssp = m_r15; m_r15 = m_usp; end
        end else if (gwe && !hits) begin
            m_r15 = gd;
        end
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // one write cycle; outputs compared half a cycle later
    task automatic step(string tag, bit we, logic [2:0] sel, logic [31:0] d, bit gwe, logic [31:0] gd);
        @(negedge clk);
        ctl_we = we; ctl_sel = sel; ctl_wdata = d; gr_we = gwe; gr_wdata = gd;
        @(posedge clk);
        model_apply(we, sel, d, gwe, gd);
        @(negedge clk);
        ctl_we = 1'b0; gr_we = 1'b0;
        #0.5;
        chk({tag, " word"}, status_out, exp_word());
        chk({tag, " sp"}, sp_out, m_r15);
    endtask

    task automatic rd_chk(string tag, logic [2:0] s);
        rd_sel = s;
        #0.4;
        chk(tag, rd_data, exp_read(s));
    endtask

    task automatic read_all(string tag);
        @(negedge clk);
        #0.2;
        for (int s = 0; s < 8; s++) rd_chk(tag, 3'(s));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ctl_we = 1'b0; gr_we = 1'b0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8.0 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        do_reset();
        // R1: everything clear after reset
        read_all("R1 reset");
        chk("R1 reset sp", sp_out, 32'h0);
        chk("R1 reset word", status_out, 32'h0);

        // R11 baseline: register-file write alone reaches R15
        step("R11 gr write", 1'b0, 3'd0, '0, 1'b1, 32'h0000_1111);
        // R9: S=0, system alias writes R15, user alias writes saved copy
        step("R9 sys alias", 1'b1, 3'd5, 32'h0000_AAAA, 1'b0, '0);
        chk("R9 sys alias r15", sp_out, 32'h0000_AAAA);
        step("R9 usr alias", 1'b1, 3'd6, 32'h0000_5555, 1'b0, '0);
        read_all("R8 aliases S0");
        // R11: control write on R15 beats register-file write
        step("R11 ctl beats gr", 1'b1, 3'd4, 32'h0000_BBBB, 1'b1, 32'h0000_CCCC);
        chk("R11 ctl beats gr", sp_out, 32'h0000_BBBB);

        // R7 + R11: S 0->1 swap overrides same-cycle register-file write
        step("R7 swap", 1'b1, 3'd1, 32'h0000_0020, 1'b1, 32'h0000_DEAD);
        chk("R7 r15 from usr", sp_out, 32'h0000_5555);
        read_all("R8 aliases S1");
        chk("R7 sys saved", rd_data, 32'h0);
        rd_chk("R7 sys saved", 3'd5);
        chk("R7 sys saved literal", rd_data, 32'h0000_BBBB);

        // R2: all-ones word write, unused bits ignored; S stays 1 so no swap
        step("R2 ones", 1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, '0);
        chk("R2 layout", status_out, 32'h001F_073F);
        chk("R2 no swap", sp_out, 32'h0000_5555);
        // R4: lower-half write while mask is 31 lands at 19
        step("R4 floor", 1'b1, 3'd3, 32'h0000_0003, 1'b0, '0);
        chk("R4 floor", status_out[20:16], 32'd19);
        // R3: control field from bits 2:0
        step("R3 ctrl", 1'b1, 3'd2, 32'hFFFF_FFF5, 1'b0, '0);
        chk("R3 ctrl", status_out[10:8], 32'd5);
        // R10 + R6: word write clears S (swap 1->0) and mask floor applies
        step("R10 word", 1'b1, 3'd0, 32'h0005_0201, 1'b0, '0);
        chk("R6 r15 from sys", sp_out, 32'h0000_BBBB);
        chk("R10 word", status_out, 32'h0015_0201);
        read_all("R6 aliases");
        // R12: code 7 write changes nothing
        step("R12 none", 1'b1, 3'd7, 32'hFFFF_FFFF, 1'b0, '0);
        chk("R12 none", status_out, 32'h0015_0201);

        // R5 after reset: mask writes below the upper half store as written
        do_reset();
        step("R5 mask", 1'b1, 3'd3, 32'h0000_000C, 1'b0, '0);
        chk("R5 mask", status_out[20:16], 32'd12);
        step("R5 mask up", 1'b1, 3'd3, 32'h0000_0016, 1'b0, '0);
        chk("R5 mask up", status_out[20:16], 32'd22);

        // random mix, R1..R12 against the model
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  sel = 3'($urandom_range(0, 7));
            logic [31:0] d   = $urandom;
            bit          gwe = 1'($urandom);
            if (i == 200) do_reset();
            step("R12 random", 1'($urandom_range(0, 3) != 0), sel, d, gwe, $urandom);
            if (i % 8 == 0) read_all("R8 random read");
        end
        finish_run();
    end
endmodule